// File: doc/BRIEF.md
# Character Pattern Bank Mapper with Per-Slot ROM/RAM Routing

This block sits between the picture unit's pattern fetches and the cartridge character memories. The lower 8 KB of the 14-bit pattern address is divided into eight 1 KB slots. Each slot takes its bank number from one of six bank registers: two wide (2 KB) registers and four narrow (1 KB) registers. A control bit swaps the lower and upper halves of pattern space between the wide and the narrow registers.

Once a slot's bank number is known, a routing stage decides whether the fetch goes to character ROM or to a small 8 KB character RAM. The routing policy comes from a strap input with three policies. In the flag policy, each slot is routed by bit 6 of its own bank number. In the RAM-only policy, a board without character ROM sends everything to RAM. In the pair policy, two fixed bank numbers point at RAM. The output is a physical address plus a RAM select, combinational from the registered bank state and the live fetch address.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset, every bank register is 0 and the swap bit is clear. In the flag policy, slots 0 and 2 map to ROM bank 0, slots 1 and 3 to ROM bank 1, and slots 4 to 7 to ROM bank 0.
- R2: The slot number is `pat_addr[12:10]`. `phys_addr[9:0]` equals `pat_addr[9:0]`, and `pat_addr[13]` has no effect on either output.
- R3: A wide register drives two adjacent slots: the even slot uses its value and the odd slot uses its value plus one, modulo 256 (so 0xFF gives 0x00).
- R4: With the swap bit clear, wide register 0 feeds slots 0–1, wide register 1 feeds slots 2–3, and narrow registers 0–3 feed slots 4–7 in order.
- R5: With the swap bit set, narrow registers 0–3 feed slots 0–3 in order, wide register 0 feeds slots 4–5 and wide register 1 feeds slots 6–7.
- R6: In the flag policy (`route_mode` 0 or 3), a bank number with bit 6 set selects RAM page `bank[2:0]`. Otherwise the fetch goes to ROM with the full 8-bit bank.
- R7: In the RAM-only policy (`route_mode` 1), every fetch goes to RAM with page `bank[2:0]`.
- R8: In the pair policy (`route_mode` 2), bank 8 selects RAM page 0 and bank 9 selects RAM page 1. Every other bank goes to ROM with the full bank.
- R9: A write is taken on a clock edge where `wr_en` is 1 and is visible on the outputs from that edge on. Select codes are: 0 and 1 for the wide registers, 2 to 5 for narrow registers 0 to 3, and 6 for control, where only data bit 7 (the swap bit) is kept. Select 7, and any cycle with `wr_en` at 0, change nothing.
- R10: A ROM fetch gives `phys_addr = {bank[7:0], pat_addr[9:0]}` with `use_ram` = 0. A RAM fetch gives `phys_addr = {5'b0, page[2:0], pat_addr[9:0]}` with `use_ram` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Register write data |
| route_mode | input | 2 | ROM/RAM routing policy (0/3 flag, 1 RAM-only, 2 pair) |
| pat_addr | input | 14 | Pattern fetch address |
| phys_addr | output | 18 | Physical character memory address |
| use_ram | output | 1 | 1 selects character RAM, 0 selects character ROM |

## Verification
On every cycle, the assertions check four things:
- Bank state holds steady when no write is strobed.
- A control write leaves the swap bit equal to data bit 7.
- A RAM fetch never carries upper address bits.
- The RAM-only and pair policies only ever produce RAM fetches to their allowed pages.

Slot-to-register assignment under both swap settings, the plus-one odd slot and its wrap, the flag bit at the ROM/RAM boundary (a wide value of 0x3F splitting one pair across ROM and RAM), and ignored writes can only be shown by the bench scenarios. The bench compares every slot against its behavioural model.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int BANK_W     = 8;   // bank number width
  localparam int OFF_W      = 10;  // 1 KB offset width
  localparam int SLOT_W     = 3;   // eight slots
  localparam int PAGE_W     = 3;   // 8 KB of character RAM
  localparam int NUM_WIDE   = 2;
  localparam int NUM_NARROW = 4;
  localparam int FLAG_BIT   = 6;
  localparam int PAIR_BASE  = 8;
  localparam int SWAP_BIT   = 7;

  typedef enum logic [1:0] {
    ROUTE_FLAG     = 2'd0,
    ROUTE_RAM_ONLY = 2'd1,
    ROUTE_PAIR     = 2'd2,
    ROUTE_FLAG_ALT = 2'd3
  } route_mode_e;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_map_pkg::*;
#(
  parameter int BW  = BANK_W,
  parameter int NW  = NUM_WIDE,
  parameter int NN  = NUM_NARROW,
  parameter int SB  = SWAP_BIT,
  localparam int CTRL_SEL = NW + NN,
  localparam int SEL_W    = $clog2(CTRL_SEL + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [BW-1:0]         wr_data,
  output logic [NW-1:0][BW-1:0] wide_q,
  output logic [NN-1:0][BW-1:0] narrow_q,
  output logic                  swap_q
);
  logic [NW-1:0][BW-1:0] wide_d;
  logic [NN-1:0][BW-1:0] narrow_d;
  logic                  swap_d;

  // next-state
  always_comb begin
    wide_d   = wide_q;
    narrow_d = narrow_q;
    swap_d   = swap_q;
    if (wr_en) begin
      for (int i = 0; i < NW; i++)
        if (int'(wr_sel) == i) wide_d[i] = wr_data;
      for (int j = 0; j < NN; j++)
        if (int'(wr_sel) == NW + j) narrow_d[j] = wr_data;
      if (int'(wr_sel) == CTRL_SEL) swap_d = wr_data[SB];
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q   <= '0;
      narrow_q <= '0;
      swap_q   <= 1'b0;
    end else begin
      wide_q   <= wide_d;
      narrow_q <= narrow_d;
      swap_q   <= swap_d;
    end
  end

  // R9: no strobe, no change
  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(wide_q) && $stable(narrow_q) && $stable(swap_q)));

  // R5/R9: control write keeps only the swap bit
  assert_swap_from_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_sel) == CTRL_SEL) |=> (swap_q == $past(wr_data[SB])));
endmodule

// File: rtl/chr_slot_bank.sv
module chr_slot_bank
  import chr_map_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int NW = NUM_WIDE,
  parameter int NN = NUM_NARROW,
  parameter int SW = SLOT_W,
  localparam int NUM_SLOTS = 1 << SW,
  localparam int HALF      = NUM_SLOTS / 2
) (
  input  logic [NW-1:0][BW-1:0] wide_q,
  input  logic [NN-1:0][BW-1:0] narrow_q,
  input  logic                  swap,
  input  logic [SW-1:0]         slot,
  output logic [BW-1:0]         bank
);
  // bank table in unswapped order: wide pairs low, narrow high
  logic [NUM_SLOTS-1:0][BW-1:0] table_w;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g < HALF) begin : g_wide
      assign table_w[g] = wide_q[g / 2] + BW'(g % 2);
    end else begin : g_narrow
      assign table_w[g] = narrow_q[g - HALF];
    end
  end

  // swapping the halves is a flip of the slot's top bit
  logic [SW-1:0] eff_slot;
  always_comb begin
    eff_slot = slot;
    eff_slot[SW-1] = slot[SW-1] ^ swap;
  end

  assign bank = table_w[eff_slot];
endmodule

// File: rtl/chr_route.sv
module chr_route
  import chr_map_pkg::*;
#(
  parameter int BW    = BANK_W,
  parameter int OW    = OFF_W,
  parameter int PW    = PAGE_W,
  parameter int FB    = FLAG_BIT,
  parameter int PBASE = PAIR_BASE,
  localparam int PHYS_W = BW + OW
) (
  input  logic [BW-1:0]     bank,
  input  route_mode_e       mode,
  input  logic [OW-1:0]     offset,
  output logic              use_ram,
  output logic [PHYS_W-1:0] phys_addr
);
  logic [PW-1:0] page;

  always_comb begin
    use_ram = 1'b0;
    page    = bank[PW-1:0];
    unique case (mode)
      ROUTE_FLAG, ROUTE_FLAG_ALT: use_ram = bank[FB];
      ROUTE_RAM_ONLY:             use_ram = 1'b1;
      ROUTE_PAIR: begin
        if (bank == BW'(PBASE) || bank == BW'(PBASE + 1)) begin
          use_ram = 1'b1;
          page    = PW'(bank - BW'(PBASE));
        end
      end
    endcase
  end

  always_comb begin
    if (use_ram) phys_addr = {{(BW - PW){1'b0}}, page, offset};
    else         phys_addr = {bank, offset};
  end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int OW = OFF_W,
  parameter int SW = SLOT_W,
  parameter int PW = PAGE_W,
  parameter int NW = NUM_WIDE,
  parameter int NN = NUM_NARROW,
  localparam int SEL_W  = $clog2(NW + NN + 1),
  localparam int PAT_W  = OW + SW + 1,
  localparam int PHYS_W = BW + OW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BW-1:0]     wr_data,
  input  logic [1:0]        route_mode,
  input  logic [PAT_W-1:0]  pat_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              use_ram
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  logic rst_n_int;
  assign rst_n_int = rst_sync[1];

  logic [NW-1:0][BW-1:0] wide_q;
  logic [NN-1:0][BW-1:0] narrow_q;
  logic                  swap_q;
  logic [BW-1:0]         bank;
  route_mode_e           mode;

  assign mode = route_mode_e'(route_mode);

  chr_bank_regs #(.BW(BW), .NW(NW), .NN(NN)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wide_q(wide_q), .narrow_q(narrow_q), .swap_q(swap_q)
  );

  chr_slot_bank #(.BW(BW), .NW(NW), .NN(NN), .SW(SW)) u_slot (
    .wide_q(wide_q), .narrow_q(narrow_q), .swap(swap_q),
    .slot(pat_addr[OW +: SW]), .bank(bank)
  );

  chr_route #(.BW(BW), .OW(OW), .PW(PW)) u_route (
    .bank(bank), .mode(mode), .offset(pat_addr[OW-1:0]),
    .use_ram(use_ram), .phys_addr(phys_addr)
  );

  // R10: RAM fetches carry no bits above the page
  assert_ram_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    use_ram |-> (phys_addr[PHYS_W-1:OW+PW] == '0));

  // R7: RAM-only boards never fetch from ROM
  assert_ram_only_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode == ROUTE_RAM_ONLY) |-> use_ram);

  // R8: pair policy reaches only RAM pages 0 and 1
  assert_pair_pages_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode == ROUTE_PAIR && use_ram) |-> (phys_addr[OW+PW-1:OW+1] == '0));
endmodule

// File: tb/chr_bank_mapper_bench.sv
module chr_bank_mapper_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  route_mode = 2'd0;
  logic [13:0] pat_addr = '0;
  logic [17:0] phys_addr;
  logic        use_ram;

  int errors = 0;
  int checks = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  int wide_m[2];
  int narrow_m[4];
  bit swap_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_bank_mapper u_chr_bank_mapper (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .route_mode(route_mode), .pat_addr(pat_addr), .phys_addr(phys_addr), .use_ram(use_ram)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_m = '{0, 0};
      narrow_m = '{0, 0, 0, 0};
      swap_m = 0;
    end else if (wr_en) begin
      if (wr_sel < 2) wide_m[wr_sel] = wr_data;
      else if (wr_sel < 6) narrow_m[wr_sel - 2] = wr_data;
      else if (wr_sel == 6) swap_m = wr_data[7];
    end
  end

  function automatic int model_bank(int slot);
    int s;
    s = swap_m ? (slot + 4) % 8 : slot;
    if (s < 4) return (wide_m[s / 2] + (s % 2)) % 256;
    return narrow_m[s - 4];
  endfunction

  // returns {ram, phys}
  function automatic logic [18:0] model_out(logic [13:0] a, int mode);
    int b, off, page;
    bit ram;
    b = model_bank(int'(a[12:10]));
    off = int'(a[9:0]);
    ram = 0;
    page = b % 8;
    if (mode == 1) ram = 1;
    else if (mode == 2) begin
      if (b == 8 || b == 9) begin ram = 1; page = b - 8; end
    end else ram = ((b / 64) % 2) == 1;
    if (ram) return {1'b1, 18'(page * 1024 + off)};
    return {1'b0, 18'(b * 1024 + off)};
  endfunction

  always @(negedge clk) begin
    if (checking && !done) begin
      logic [18:0] exp_v;
      exp_v = model_out(pat_addr, int'(route_mode));
      checks++;
      if ({use_ram, phys_addr} !== exp_v) begin
        errors++;
        $display("FAIL %s: addr=%h mode=%0d got ram=%0b phys=%h expected ram=%0b phys=%h",
                 cur_req, pat_addr, route_mode, use_ram, phys_addr, exp_v[18], exp_v[17:0]);
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic sweep(input bit hi);
    for (int s = 0; s < 8; s++) begin
      @(posedge clk); #1;
      pat_addr = {hi, 3'(s), 10'(s * 97 + 5)};
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 checking = 1'b1;

    // R1: reset state, explicit value for slot 1
    cur_req = "R1";
    pat_addr = 14'h0400;
    @(negedge clk);
    checks++;
    if (phys_addr !== 18'h00400 || use_ram !== 1'b0) begin
      errors++;
      $display("FAIL R1: got ram=%0b phys=%h expected ram=0 phys=00400", use_ram, phys_addr);
    end
    sweep(0);

    // R3 R4 R2: unswapped layout, bit 13 toggled
    cur_req = "R4";
    wr(0, 8'h10); wr(1, 8'h22);
    wr(2, 8'h30); wr(3, 8'h31); wr(4, 8'h32); wr(5, 8'h33);
    sweep(0);
    cur_req = "R2";
    sweep(1);
    cur_req = "R3";
    wr(1, 8'hFF);
    sweep(0);

    // R5: swapped layout; R9 control keeps bit 7 only
    cur_req = "R5";
    wr(6, 8'h80);
    sweep(0);
    cur_req = "R9";
    wr(6, 8'h7F);
    sweep(1);
    wr(6, 8'hFF);
    sweep(0);
    wr(6, 8'h00);

    // R6: flag policy, 0x3F pair splits across ROM/RAM
    cur_req = "R6";
    wr(0, 8'h3F); wr(1, 8'hC5);
    wr(2, 8'h45); wr(3, 8'h47); wr(4, 8'hBF); wr(5, 8'h40);
    sweep(0);
    route_mode = 2'd3;
    sweep(1);

    // R7: RAM-only policy
    cur_req = "R7";
    route_mode = 2'd1;
    sweep(0);

    // R8: pair policy
    cur_req = "R8";
    route_mode = 2'd2;
    wr(0, 8'h08); wr(1, 8'h07);
    wr(2, 8'h09); wr(3, 8'h0A); wr(4, 8'h48); wr(5, 8'h88);
    sweep(0);
    wr(6, 8'h80);
    sweep(1);

    // R9: ignored writes
    cur_req = "R9";
    route_mode = 2'd0;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_sel = 3'd2; wr_data = 8'h5A;
    @(posedge clk); #1;
    sweep(0);
    wr(7, 8'hFF);
    sweep(0);

    // R10: address format in both directions
    cur_req = "R10";
    wr(6, 8'h00);
    wr(2, 8'hFE); wr(3, 8'h43);
    pat_addr = 14'h13FF;
    sweep(1);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule